// File: doc/BRIEF.md
# Interrupt Distributor Register Block

This block keeps the per-interrupt configuration and status for a set of interrupt lines behind a small 32-bit register bus. Software uses it to enable lines, mark them pending or clear them, choose the group of each line, and set an 8-bit priority and a CPU target mask for each line. Hardware peripheral lines raise their pending bits on a rising edge. The block presents all of this state as flat vectors to a downstream CPU interface, which does the prioritisation and delivery.

The first sixteen IDs are software-generated interrupts (SGIs). They are raised only through a packed trigger word that names the ID, the group and a list of CPUs. The block keeps one pending bit per SGI for each CPU. Enable and pending state change only through paired set and clear banks, where a one in the write data acts and a zero leaves the bit alone. Every bit that belongs to an ID above the configured count reads as zero, so software can find out how many lines exist by writing all-ones and reading the value back.

The bus has no wait states. Read data is a combinational function of the address, and a write takes effect at the clock edge on which `bus_wr` is sampled high.

Top module: `irq_distributor`

## Requirements
- R1: After reset, every enable, pending, group, priority, target and SGI pending bit is zero, and both forwarding enables are zero.
- R2: Writing ones to the set-enable bank (0x100 + 4n) sets the enable bits, and writing ones to the clear-enable bank (0x180 + 4n) clears them. Zero data bits, and bytes whose strobe is low, leave the bits unchanged. ID `id` maps to word n = id/32, bit id%32. Both offsets read back the enable word.
- R3: The set-pending bank (0x200 + 4n) and the clear-pending bank (0x280 + 4n) act on pending bits in the same way and both read the pending word. Set-pending writes to IDs 0 to 15 are ignored.
- R4: The group bank (0x080 + 4n) is read/write with one bit per ID. A 1 means group 1 and a 0 means group 0. Only bytes whose strobe is high are updated.
- R5: The priority of ID `id` is the byte at address 0x400 + id. A write updates only the byte lanes whose strobe is high.
- R6: The CPU target mask of ID `id` is byte lane id%4 of the word at 0x800 + 4*(id/4). Only the low NUM_CPU bits of each byte are stored, and the other bits read zero.
- R7: In every bank, bits and bytes that belong to IDs at or above NUM_IRQ read zero, even after all-ones has been written.
- R8: A write to 0xF00 triggers an SGI, whatever the byte strobes are. Bits 3:0 give the ID, bit 15 gives the group and bits 23:16 give the CPU list, of which only the low NUM_CPU bits are used. The trigger takes effect only when bit 15 equals the group bit of that SGI. It then sets `sgi_pending[id*NUM_CPU + cpu]` for every listed CPU. Pending bit `id` reads 1 while any CPU is pending for that SGI. The trigger offset reads zero.
- R9: A clear-pending write to an SGI ID clears that SGI's pending bit for all CPUs.
- R10: A rising edge on `irq_in[id]`, for 16 <= id < NUM_IRQ, sets pending bit `id` at the next clock edge. A line that stays high does not set the bit again after a clear. `irq_in[15:0]` are ignored.
- R11: When a clear-pending write and a rising edge on the same line fall in the same cycle, the pending bit ends up clear.
- R12: The control word at 0x000 holds the group 0 forwarding enable in bit 0 and the group 1 forwarding enable in bit 1. It is written when strobe 0 is high, and its other bits read zero.
- R13: Reserved offsets (for example 0x004, 0x300, 0xC00 and 0xF04) read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write request, sampled on the clock edge |
| bus_wstrb | input | 4 | Byte lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | NUM_IRQ | Peripheral interrupt lines, rising-edge sensitive |
| irq_pending | output | NUM_IRQ | Pending bit of each ID (for an SGI, the OR over CPUs) |
| irq_enable | output | NUM_IRQ | Enable bit of each ID |
| irq_group | output | NUM_IRQ | Group bit of each ID |
| irq_prio | output | 8*NUM_IRQ | Priority byte of each ID, ID `i` at bits 8i+7:8i |
| irq_target | output | NUM_CPU*NUM_IRQ | CPU target mask of each ID |
| sgi_pending | output | 16*NUM_CPU | SGI pending bit for each SGI and CPU |
| fwd_grp0_en | output | 1 | Group 0 forwarding enable |
| fwd_grp1_en | output | 1 | Group 1 forwarding enable |

## Verification
The bench builds the block with NUM_IRQ = 48 and NUM_CPU = 4. Because 48 is not a multiple of 32, the second bit-bank word is only half implemented and a third word is absent entirely, so the zero read-back of missing IDs is tested both inside a word and past the end of the banks. With four CPUs, the upper nibble of every target byte and of the SGI CPU list must be dropped. Writes, triggers and line edges come in random order against a reference model, and directed cases cover the clear-against-edge collision and the SGI group filter.

// File: rtl/dist_pkg.sv
package dist_pkg;
   localparam int unsigned SGI_COUNT = 16;

   typedef enum logic [3:0] {
      SEL_NONE, SEL_CTRL, SEL_GROUP, SEL_SETEN, SEL_CLREN,
      SEL_SETPD, SEL_CLRPD, SEL_PRIO, SEL_TGT, SEL_SGI
   } reg_sel_e;

   // expand byte strobes into a bit mask
   function automatic logic [31:0] lane_mask(input logic [3:0] strb);
      logic [31:0] m;
      for (int k = 0; k < 4; k++) m[k*8 +: 8] = {8{strb[k]}};
      return m;
   endfunction

   function automatic reg_sel_e decode(input logic [11:0] addr);
      reg_sel_e s;
      s = SEL_NONE;
      if (addr[11:2] == 10'h000)       s = SEL_CTRL;
      else if (addr[11:7] == 5'd1)     s = SEL_GROUP;
      else if (addr[11:7] == 5'd2)     s = SEL_SETEN;
      else if (addr[11:7] == 5'd3)     s = SEL_CLREN;
      else if (addr[11:7] == 5'd4)     s = SEL_SETPD;
      else if (addr[11:7] == 5'd5)     s = SEL_CLRPD;
      else if (addr[11:10] == 2'b01)   s = SEL_PRIO;
      else if (addr[11:10] == 2'b10)   s = SEL_TGT;
      else if (addr[11:2] == 10'h3C0)  s = SEL_SGI;
      return s;
   endfunction
endpackage

// File: rtl/dist_bit_word.sv
module dist_bit_word #(
   parameter int unsigned WORD_IDX = 0,
   parameter int unsigned NUM_IRQ  = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        grp_wr,
   input  logic        set_en_wr,
   input  logic        clr_en_wr,
   input  logic        set_pd_wr,
   input  logic        clr_pd_wr,
   input  logic [31:0] wdata,
   input  logic [31:0] lane_m,
   input  logic [31:0] hw_rise,
   output logic [31:0] en_q,
   output logic [31:0] pd_q,
   output logic [31:0] grp_q
);
   localparam int unsigned BASE = WORD_IDX * 32;

   logic [31:0] impl_m;   // IDs that exist
   logic [31:0] pd_m;     // IDs whose pending lives here (not SGIs)
   logic [31:0] wm;

   for (genvar b = 0; b < 32; b++) begin : g_mask
      assign impl_m[b] = (BASE + b < NUM_IRQ);
      assign pd_m[b]   = (BASE + b < NUM_IRQ) && (BASE + b >= 16);
   end

   assign wm = wdata & lane_m;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         pd_q  <= '0;
         grp_q <= '0;
      end else begin
         if (grp_wr)
            grp_q <= ((grp_q & ~lane_m) | wm) & impl_m;
         if (set_en_wr)
            en_q <= en_q | (wm & impl_m);
         else if (clr_en_wr)
            en_q <= en_q & ~wm;
         // clear is applied last so it wins over a same-cycle edge
         pd_q <= ((pd_q | (set_pd_wr ? wm : '0) | hw_rise)
                  & ~(clr_pd_wr ? wm : '0)) & pd_m;
      end
   end

   AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_en_wr |=> ((en_q & $past(wm & impl_m)) == $past(wm & impl_m))); // R2
   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_en_wr && !clr_en_wr) |=> $stable(en_q)); // R2
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pd_wr |=> ((pd_q & $past(wm)) == '0)); // R11
   AST_SGI_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
      set_pd_wr |=> ((pd_q & ~pd_m) == '0)); // R3
endmodule

// File: rtl/dist_byte_bank.sv
module dist_byte_bank #(
   parameter int unsigned NUM_ENTRY = 64,
   parameter int unsigned FIELD_W   = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr,
   input  logic [7:0]                     word_idx,
   input  logic [3:0]                     strb,
   input  logic [31:0]                    wdata,
   input  logic [7:0]                     rd_word,
   output logic [31:0]                    rd_data,
   output logic [NUM_ENTRY*FIELD_W-1:0]   field_flat
);
   if (FIELD_W < 1 || FIELD_W > 8) begin : g_bad_width
      $error("dist_byte_bank: FIELD_W must be 1..8");
   end

   logic [FIELD_W-1:0] mem [NUM_ENTRY];
   logic               unused_wdata;

   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < NUM_ENTRY; e++) mem[e] <= '0;
      end else if (wr) begin
         for (int e = 0; e < NUM_ENTRY; e++)
            if (word_idx == 8'(e / 4) && strb[e % 4])
               mem[e] <= wdata[(e % 4) * 8 +: FIELD_W];
      end
   end

   always_comb begin
      rd_data = '0;
      for (int e = 0; e < NUM_ENTRY; e++)
         if (rd_word == 8'(e / 4))
            rd_data[(e % 4) * 8 +: FIELD_W] = mem[e];
   end

   for (genvar e = 0; e < NUM_ENTRY; e++) begin : g_flat
      assign field_flat[e*FIELD_W +: FIELD_W] = mem[e];
   end

   AST_LANE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && word_idx == 8'd0 && !strb[0]) |=> $stable(mem[0])); // R5
endmodule

// File: rtl/dist_sgi_unit.sv
module dist_sgi_unit #(
   parameter int unsigned NUM_CPU = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  trig,
   input  logic [3:0]            trig_id,
   input  logic                  trig_grp,
   input  logic [NUM_CPU-1:0]    trig_list,
   input  logic [15:0]           sgi_grp,
   input  logic                  clr_wr,
   input  logic [15:0]           clr_m,
   output logic [16*NUM_CPU-1:0] pend_flat,
   output logic [15:0]           pend_any
);
   logic [NUM_CPU-1:0] pend [16];
   logic               grp_ok;

   assign grp_ok = (trig_grp == sgi_grp[trig_id]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) pend[i] <= '0;
      end else begin
         for (int i = 0; i < 16; i++) begin
            if (clr_wr && clr_m[i])
               pend[i] <= '0;
            else if (trig && grp_ok && trig_id == 4'(i))
               pend[i] <= pend[i] | trig_list;
         end
      end
   end

   for (genvar i = 0; i < 16; i++) begin : g_out
      assign pend_flat[i*NUM_CPU +: NUM_CPU] = pend[i];
      assign pend_any[i] = |pend[i];
   end

   AST_SGI_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && grp_ok) |=> ((pend[$past(trig_id)] & $past(trig_list)) == $past(trig_list))); // R8
   AST_SGI_GRP_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !grp_ok) |=> $stable(pend_flat)); // R8
   AST_SGI_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((pend_any & $past(clr_m)) == '0)); // R9
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
   import dist_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 64,
   parameter int unsigned NUM_CPU = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [11:0]                bus_addr,
   input  logic                       bus_wr,
   input  logic [3:0]                 bus_wstrb,
   input  logic [31:0]                bus_wdata,
   output logic [31:0]                bus_rdata,
   input  logic [NUM_IRQ-1:0]         irq_in,
   output logic [NUM_IRQ-1:0]         irq_pending,
   output logic [NUM_IRQ-1:0]         irq_enable,
   output logic [NUM_IRQ-1:0]         irq_group,
   output logic [NUM_IRQ*8-1:0]       irq_prio,
   output logic [NUM_IRQ*NUM_CPU-1:0] irq_target,
   output logic [16*NUM_CPU-1:0]      sgi_pending,
   output logic                       fwd_grp0_en,
   output logic                       fwd_grp1_en
);
   localparam int unsigned NUM_WORDS = (NUM_IRQ + 31) / 32;
   localparam int unsigned PAD_W     = NUM_WORDS * 32;

   if (NUM_IRQ < 32 || NUM_IRQ > 1020) begin : g_bad_irq
      $error("irq_distributor: NUM_IRQ must be 32..1020");
   end
   if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
      $error("irq_distributor: NUM_CPU must be 1..8");
   end

   reg_sel_e          sel;
   logic [31:0]       lane_m;
   logic [4:0]        word_n;
   logic [NUM_IRQ-1:0] irq_prev, rise;
   logic [PAD_W-1:0]  rise_pad, en_flat, pd_flat, grp_flat;
   logic [31:0]       en_w [NUM_WORDS];
   logic [31:0]       pd_w [NUM_WORDS];
   logic [31:0]       grp_w [NUM_WORDS];
   logic [15:0]       sgi_any;
   logic [31:0]       prio_rd, tgt_rd;
   logic [31:0]       rd_en, rd_pd, rd_grp;
   logic [1:0]        ctrl_q;
   logic              unused_addr;

   assign sel         = decode(bus_addr);
   assign lane_m      = lane_mask(bus_wstrb);
   assign word_n      = bus_addr[6:2];
   assign unused_addr = ^bus_addr[1:0];

   // rising-edge detect on peripheral lines
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_prev <= '0;
      else        irq_prev <= irq_in;
   end
   assign rise     = irq_in & ~irq_prev;
   assign rise_pad = PAD_W'(rise);

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      dist_bit_word #(.WORD_IDX(w), .NUM_IRQ(NUM_IRQ)) u_word (
         .clk       (clk),
         .rst_n     (rst_n),
         .grp_wr    (bus_wr && sel == SEL_GROUP && word_n == 5'(w)),
         .set_en_wr (bus_wr && sel == SEL_SETEN && word_n == 5'(w)),
         .clr_en_wr (bus_wr && sel == SEL_CLREN && word_n == 5'(w)),
         .set_pd_wr (bus_wr && sel == SEL_SETPD && word_n == 5'(w)),
         .clr_pd_wr (bus_wr && sel == SEL_CLRPD && word_n == 5'(w)),
         .wdata     (bus_wdata),
         .lane_m    (lane_m),
         .hw_rise   (rise_pad[w*32 +: 32]),
         .en_q      (en_w[w]),
         .pd_q      (pd_w[w]),
         .grp_q     (grp_w[w])
      );
      assign en_flat[w*32 +: 32]  = en_w[w];
      assign pd_flat[w*32 +: 32]  = pd_w[w];
      assign grp_flat[w*32 +: 32] = grp_w[w];
   end

   dist_sgi_unit #(.NUM_CPU(NUM_CPU)) u_sgi (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (bus_wr && sel == SEL_SGI),
      .trig_id   (bus_wdata[3:0]),
      .trig_grp  (bus_wdata[15]),
      .trig_list (bus_wdata[16 +: NUM_CPU]),
      .sgi_grp   (grp_w[0][15:0]),
      .clr_wr    (bus_wr && sel == SEL_CLRPD && word_n == 5'd0),
      .clr_m     (bus_wdata[15:0] & lane_m[15:0]),
      .pend_flat (sgi_pending),
      .pend_any  (sgi_any)
   );

   dist_byte_bank #(.NUM_ENTRY(NUM_IRQ), .FIELD_W(8)) u_prio (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (bus_wr && sel == SEL_PRIO),
      .word_idx   (bus_addr[9:2]),
      .strb       (bus_wstrb),
      .wdata      (bus_wdata),
      .rd_word    (bus_addr[9:2]),
      .rd_data    (prio_rd),
      .field_flat (irq_prio)
   );

   dist_byte_bank #(.NUM_ENTRY(NUM_IRQ), .FIELD_W(NUM_CPU)) u_tgt (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (bus_wr && sel == SEL_TGT),
      .word_idx   (bus_addr[9:2]),
      .strb       (bus_wstrb),
      .wdata      (bus_wdata),
      .rd_word    (bus_addr[9:2]),
      .rd_data    (tgt_rd),
      .field_flat (irq_target)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      ctrl_q <= '0;
      else if (bus_wr && sel == SEL_CTRL && bus_wstrb[0]) ctrl_q <= bus_wdata[1:0];
   end

   assign fwd_grp0_en = ctrl_q[0];
   assign fwd_grp1_en = ctrl_q[1];
   assign irq_enable  = en_flat[NUM_IRQ-1:0];
   assign irq_group   = grp_flat[NUM_IRQ-1:0];
   assign irq_pending = pd_flat[NUM_IRQ-1:0] | {{(NUM_IRQ-16){1'b0}}, sgi_any};

   always_comb begin
      rd_en  = '0;
      rd_pd  = '0;
      rd_grp = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (word_n == 5'(w)) begin
            rd_en  = en_w[w];
            rd_pd  = pd_w[w];
            rd_grp = grp_w[w];
         end
      end
      if (word_n == 5'd0) rd_pd[15:0] = sgi_any;
      case (sel)
         SEL_CTRL:             bus_rdata = {30'b0, ctrl_q};
         SEL_GROUP:            bus_rdata = rd_grp;
         SEL_SETEN, SEL_CLREN: bus_rdata = rd_en;
         SEL_SETPD, SEL_CLRPD: bus_rdata = rd_pd;
         SEL_PRIO:             bus_rdata = prio_rd;
         SEL_TGT:              bus_rdata = tgt_rd;
         default:              bus_rdata = '0;
      endcase
   end

   AST_RSVD_NOEFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (sel == SEL_NONE)) |=> ($stable(irq_enable) && $stable(irq_group)
         && $stable(irq_prio) && $stable(irq_target) && $stable(ctrl_q))); // R13
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && sel == SEL_CTRL) |=> $stable({fwd_grp1_en, fwd_grp0_en})); // R12
endmodule

// File: tb/test_irq_distributor.sv
module test_irq_distributor;
   localparam int CLK_PERIOD = 10;
   localparam int NI = 48;
   localparam int NC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [3:0]    bus_wstrb = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NI-1:0] irq_in = '0;
   logic [NI-1:0] irq_pending, irq_enable, irq_group;
   logic [NI*8-1:0]  irq_prio;
   logic [NI*NC-1:0] irq_target;
   logic [16*NC-1:0] sgi_pending;
   logic          fwd_grp0_en, fwd_grp1_en;

   irq_distributor #(.NUM_IRQ(NI), .NUM_CPU(NC)) i_irq_distributor (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_in(irq_in), .irq_pending(irq_pending), .irq_enable(irq_enable),
      .irq_group(irq_group), .irq_prio(irq_prio), .irq_target(irq_target),
      .sgi_pending(sgi_pending), .fwd_grp0_en(fwd_grp0_en), .fwd_grp1_en(fwd_grp1_en)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_err = 0;

   // reference model
   bit            m_en [64];
   bit            m_pd [64];
   bit            m_grp [64];
   logic [7:0]    m_prio [64];
   logic [3:0]    m_tgt [64];
   logic [3:0]    m_sgi [16];
   logic [1:0]    m_ctrl;
   logic [NI-1:0] m_prev;

   task automatic model_reset();
      for (int i = 0; i < 64; i++) begin
         m_en[i] = 0; m_pd[i] = 0; m_grp[i] = 0; m_prio[i] = '0; m_tgt[i] = '0;
      end
      for (int i = 0; i < 16; i++) m_sgi[i] = '0;
      m_ctrl = '0;
      m_prev = '0;
   endtask

   task automatic model_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
      logic [31:0] sm;
      for (int k = 0; k < 4; k++) sm[k*8 +: 8] = {8{s[k]}};
      if (a[11:2] == 10'h0) begin
         if (s[0]) m_ctrl = d[1:0];
      end else if (a[11:7] >= 5'd1 && a[11:7] <= 5'd5) begin
         for (int b = 0; b < 32; b++) begin
            int id;
            id = int'(a[6:2]) * 32 + b;
            if (id < NI && sm[b]) begin
               case (a[11:7])
                  5'd1: m_grp[id] = d[b];
                  5'd2: if (d[b]) m_en[id] = 1;
                  5'd3: if (d[b]) m_en[id] = 0;
                  5'd4: if (d[b] && id >= 16) m_pd[id] = 1;
                  default: if (d[b]) begin
                     if (id < 16) m_sgi[id] = '0;
                     else m_pd[id] = 0;
                  end
               endcase
            end
         end
      end else if (a[11:10] == 2'b01 || a[11:10] == 2'b10) begin
         for (int k = 0; k < 4; k++) begin
            int id;
            id = int'(a[9:2]) * 4 + k;
            if (id < NI && s[k]) begin
               if (a[11:10] == 2'b01) m_prio[id] = d[k*8 +: 8];
               else m_tgt[id] = d[k*8 +: 4];
            end
         end
      end else if (a[11:2] == 10'h3C0) begin
         if (d[15] == m_grp[d[3:0]]) m_sgi[d[3:0]] = m_sgi[d[3:0]] | d[19:16];
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      logic [31:0] r;
      r = '0;
      if (a[11:2] == 10'h0) r = {30'b0, m_ctrl};
      else if (a[11:7] >= 5'd1 && a[11:7] <= 5'd5) begin
         for (int b = 0; b < 32; b++) begin
            int id;
            id = int'(a[6:2]) * 32 + b;
            if (id < NI) begin
               if (a[11:7] == 5'd1) r[b] = m_grp[id];
               else if (a[11:7] <= 5'd3) r[b] = m_en[id];
               else r[b] = (id < 16) ? |m_sgi[id] : m_pd[id];
            end
         end
      end else if (a[11:10] == 2'b01 || a[11:10] == 2'b10) begin
         for (int k = 0; k < 4; k++) begin
            int id;
            id = int'(a[9:2]) * 4 + k;
            if (id < NI) r[k*8 +: 8] = (a[11:10] == 2'b01) ? m_prio[id] : {4'b0, m_tgt[id]};
         end
      end
      return r;
   endfunction

   function automatic string tag_of(input logic [11:0] a);
      if (a[11:2] == 10'h0) return "R12";
      if (a[11:7] == 5'd1) return "R4";
      if (a[11:7] == 5'd2 || a[11:7] == 5'd3) return "R2";
      if (a[11:7] == 5'd4 || a[11:7] == 5'd5) return "R3";
      if (a[11:10] == 2'b01) return "R5";
      if (a[11:10] == 2'b10) return "R6";
      return "R13";
   endfunction

   task automatic check_vec(input string tag, input string what, input logic [511:0] act, input logic [511:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // one bus cycle; rising lines and the write land on the same edge
   task automatic do_cycle(input logic [NI-1:0] iv, input logic wr,
                           input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
      logic [NI-1:0] rise;
      @(negedge clk);
      irq_in = iv; bus_wr = wr; bus_addr = a; bus_wdata = d; bus_wstrb = s;
      rise = iv & ~m_prev;
      for (int id = 16; id < NI; id++) if (rise[id]) m_pd[id] = 1;
      m_prev = iv;
      if (wr) model_write(a, d, s);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
      do_cycle(irq_in, 1'b1, a, d, s);
   endtask

   task automatic rd_check(input string tag, input logic [11:0] a);
      bus_addr = a;
      #1;
      check_vec(tag, $sformatf("read 0x%h", a), 512'(bus_rdata), 512'(exp_read(a)));
   endtask

   task automatic rd_expect(input string tag, input logic [11:0] a, input logic [31:0] e);
      bus_addr = a;
      #1;
      check_vec(tag, $sformatf("read 0x%h", a), 512'(bus_rdata), 512'(e));
   endtask

   task automatic check_ports(input string tag);
      logic [NI-1:0] e_pd, e_en, e_grp;
      logic [NI*8-1:0] e_pr;
      logic [NI*NC-1:0] e_tg;
      logic [16*NC-1:0] e_sg;
      for (int id = 0; id < NI; id++) begin
         e_pd[id] = (id < 16) ? |m_sgi[id] : m_pd[id];
         e_en[id] = m_en[id];
         e_grp[id] = m_grp[id];
         e_pr[id*8 +: 8] = m_prio[id];
         e_tg[id*NC +: NC] = m_tgt[id];
      end
      for (int s = 0; s < 16; s++) e_sg[s*NC +: NC] = m_sgi[s];
      #1;
      check_vec(tag, "irq_pending", 512'(irq_pending), 512'(e_pd));
      check_vec(tag, "irq_enable", 512'(irq_enable), 512'(e_en));
      check_vec(tag, "irq_group", 512'(irq_group), 512'(e_grp));
      check_vec(tag, "irq_prio", 512'(irq_prio), 512'(e_pr));
      check_vec(tag, "irq_target", 512'(irq_target), 512'(e_tg));
      check_vec(tag, "sgi_pending", 512'(sgi_pending), 512'(e_sg));
      check_vec(tag, "forward enables", 512'({fwd_grp1_en, fwd_grp0_en}), 512'(m_ctrl));
   endtask

   function automatic logic [11:0] rand_addr();
      logic [11:0] a;
      case ($urandom % 9)
         0: a = 12'h000;
         1: a = 12'h080 + 12'(4 * ($urandom % 3));
         2: a = 12'h100 + 12'(4 * ($urandom % 3));
         3: a = 12'h180 + 12'(4 * ($urandom % 3));
         4: a = 12'h200 + 12'(4 * ($urandom % 3));
         5: a = 12'h280 + 12'(4 * ($urandom % 3));
         6: a = 12'h400 + 12'(4 * ($urandom % 16));
         7: a = 12'h800 + 12'(4 * ($urandom % 16));
         default: case ($urandom % 4)
            0: a = 12'h004;
            1: a = 12'h300;
            2: a = 12'hC00;
            default: a = 12'hF04;
         endcase
      endcase
      return a;
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_ports("R1");
      rd_expect("R1", 12'h000, 32'h0);
      rd_expect("R1", 12'h100, 32'h0);
      rd_expect("R1", 12'h200, 32'h0);
      rd_expect("R1", 12'h400, 32'h0);
      rd_expect("R1", 12'h800, 32'h0);

      // R12 control word
      wr(12'h000, 32'hFFFF_FFFF, 4'hF);
      rd_expect("R12", 12'h000, 32'h3);
      check_ports("R12");
      wr(12'h000, 32'h0000_0002, 4'hE);
      rd_expect("R12", 12'h000, 32'h3);
      wr(12'h000, 32'h0000_0001, 4'h1);
      rd_expect("R12", 12'h000, 32'h1);

      // R2 set / clear enable with strobes
      wr(12'h100, 32'h0000_F00F, 4'h3);
      wr(12'h180, 32'h0000_0003, 4'h1);
      rd_expect("R2", 12'h100, 32'h0000_F00C);
      wr(12'h100, 32'hFFFF_0000, 4'h3);
      rd_expect("R2", 12'h180, 32'h0000_F00C);

      // R7 unimplemented IDs
      wr(12'h104, 32'hFFFF_FFFF, 4'hF);
      rd_expect("R7", 12'h104, 32'h0000_FFFF);
      wr(12'h108, 32'hFFFF_FFFF, 4'hF);
      rd_expect("R7", 12'h108, 32'h0);
      wr(12'h430, 32'hFFFF_FFFF, 4'hF);
      rd_expect("R7", 12'h430, 32'h0);
      wr(12'h830, 32'hFFFF_FFFF, 4'hF);
      rd_expect("R7", 12'h830, 32'h0);

      // R6 target field width
      wr(12'h804, 32'hFFFF_FFFF, 4'hF);
      rd_expect("R6", 12'h804, 32'h0F0F_0F0F);

      // R5 byte writes to priority
      wr(12'h408, 32'h0000_AB00, 4'h2);
      rd_expect("R5", 12'h408, 32'h0000_AB00);
      wr(12'h408, 32'h5555_5511, 4'h1);
      rd_expect("R5", 12'h408, 32'h0000_AB11);

      // R3 set-pending ignores SGIs
      wr(12'h200, 32'hFFFF_FFFF, 4'hF);
      rd_expect("R3", 12'h200, 32'hFFFF_0000);
      wr(12'h280, 32'hFFFF_0000, 4'hF);
      rd_expect("R3", 12'h280, 32'h0);

      // R8 SGI trigger and group filter
      wr(12'hF00, 32'h00FF_0003, 4'hF);
      rd_expect("R8", 12'h200, 32'h0000_0008);
      check_vec("R8", "sgi_pending", 512'(sgi_pending), 512'(64'h0000_0000_0000_F000));
      wr(12'hF00, 32'h0001_8005, 4'hF);
      rd_expect("R8", 12'h200, 32'h0000_0008);
      rd_expect("R8", 12'hF00, 32'h0);
      wr(12'h080, 32'h0000_0020, 4'h1);
      wr(12'hF00, 32'h0002_8005, 4'h1);
      rd_expect("R8", 12'h200, 32'h0000_0028);
      check_ports("R8");

      // R9 clear SGI for all CPUs
      wr(12'h280, 32'h0000_0008, 4'h1);
      rd_expect("R9", 12'h200, 32'h0000_0020);
      check_ports("R9");

      // R10 peripheral edges
      do_cycle(48'h0000_0010_0000, 1'b0, 12'h200, 32'h0, 4'h0);
      rd_expect("R10", 12'h200, 32'h0010_0020);
      wr(12'h280, 32'h0010_0000, 4'h4);
      do_cycle(48'h0000_0010_0000, 1'b0, 12'h200, 32'h0, 4'h0);
      rd_expect("R10", 12'h200, 32'h0000_0020);
      do_cycle(48'h0000_0010_0004, 1'b0, 12'h200, 32'h0, 4'h0);
      rd_expect("R10", 12'h200, 32'h0000_0020);

      // R11 clear beats a same-cycle edge
      do_cycle(48'h0, 1'b0, 12'h200, 32'h0, 4'h0);
      do_cycle(48'h0002_0010_0000, 1'b1, 12'h284, 32'h0000_0002, 4'h1);
      rd_expect("R11", 12'h204, 32'h0);
      check_ports("R11");
      do_cycle(48'h0, 1'b0, 12'h200, 32'h0, 4'h0);

      // R13 reserved offsets
      wr(12'h300, 32'hFFFF_FFFF, 4'hF);
      wr(12'h004, 32'hFFFF_FFFF, 4'hF);
      wr(12'hC00, 32'hFFFF_FFFF, 4'hF);
      wr(12'hF04, 32'hFFFF_FFFF, 4'hF);
      rd_expect("R13", 12'h300, 32'h0);
      rd_expect("R13", 12'h004, 32'h0);
      rd_expect("R13", 12'hC00, 32'h0);
      check_ports("R13");

      // random mix against the model
      for (int i = 0; i < 600; i++) begin
         logic [11:0] a;
         logic [31:0] d;
         logic [3:0]  s;
         logic [NI-1:0] iv;
         a = rand_addr();
         d = $urandom;
         s = 4'($urandom);
         if ($urandom % 6 == 0) begin
            a = 12'hF00;
            d = {8'h0, 8'($urandom), 1'($urandom), 11'h0, 4'($urandom)};
            s = 4'hF;
         end
         iv = irq_in;
         if ($urandom % 3 == 0) iv = iv ^ (NI'(1) << ($urandom % NI));
         do_cycle(iv, 1'b1, a, d, s);
         rd_check(tag_of(a), a);
         rd_check(tag_of(rand_addr()), rand_addr());
         if (i % 25 == 0) check_ports("R10");
      end
      check_ports("R3");

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule